// File: doc/BRIEF.md
# Serial Time Slot Interchange Switch

This block is a non-blocking time slot interchanger for framed TDM serial links. Sixteen receive lines each carry a frame of 32 eight-bit channels, sent MSB first. A single frame pulse marks bit 0 of channel 0, and one frame spans 256 bit clocks. Each received channel is deserialized and stored in a two-page data memory. On every transmit line and time slot, a per-slot connection word chooses which stored input channel is sent. Any of the 512 input channels can go to any of the 512 output slots.

Each output slot can be set to a fixed delay of one frame or to the shortest delay the timing allows. It can also be left undriven, or it can send a byte held in its connection word in place of switched data. Each receive line has a programmable bit offset, so a line that lags the frame pulse is still cut into channels on its own boundaries. A global drive-enable input can silence every transmit line. The host writes connection words and offsets through a synchronous write port. A block write fills all 32 slots of one transmit line with the same word in one cycle.

Top module: `tsi_switch`

## Requirements
- R1: After reset every connection word is cleared, so `tx_oe_o` is low on all lines until a slot is written with its drive bit set.
- R2: `fp_i` high marks bit position 0 of a frame, and the position then advances by one each clock modulo 256. Output slot n occupies positions 8n..8n+7 and is sent MSB first. A slot in fixed-delay mode (word bit 9 = 1) sends the byte that its source stream (bits 8:5) and channel (bits 4:0) received in the previous frame.
- R3: A slot in minimum-delay mode (bit 9 = 0) sends the source byte of the current frame when the source channel is lower than the output slot number (zero input offset). Otherwise it sends the source byte of the previous frame.
- R4: A slot whose drive bit (bit 11) is 0 keeps `tx_oe_o` low for all eight bit times of that slot. A slot whose drive bit is 1 keeps `tx_oe_o` high for all eight bit times, and the value does not change inside a slot.
- R5: While `ode_i` is low, every bit of `tx_oe_o` is low, whatever the connection words hold. Normal driving resumes once `ode_i` returns high.
- R6: A slot whose host-byte bit (bit 10) is 1 sends word bits 7:0 in place of switched data.
- R7: A receive line with an offset of k bit clocks has channel c, bit b sampled at frame position 8c+b+k modulo 256, and that data switches correctly.
- R8: A write with `cfg_blk_i` high and address bit 9 = 0 stores the data word in all 32 slots of the transmit line given by address bits 8:5.
- R9: A write with address bit 9 = 1 sets the offset of receive line address bits 3:0 to data bits 7:0. With bit 9 = 0 and `cfg_blk_i` low, the write sets the word of line bits 8:5, slot bits 4:0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock; one clock per serial bit |
| rst_ni | input | 1 | Synchronous active-low reset |
| fp_i | input | 1 | Frame pulse, high during bit position 0 |
| rx_i | input | 16 | Serial receive lines |
| ode_i | input | 1 | Global drive enable for all transmit lines |
| cfg_we_i | input | 1 | Host write strobe |
| cfg_blk_i | input | 1 | Block write: fill all slots of one transmit line |
| cfg_addr_i | input | 10 | Host address: bit 9 selects offset (1) or connection word (0) |
| cfg_wdata_i | input | 12 | Host write data |
| tx_o | output | 16 | Serial transmit lines |
| tx_oe_o | output | 16 | Per-line drive enable; low means high impedance |

## Verification
The properties assume that the frame pulse arrives exactly every 256 clocks, so the internal position counter steps by one everywhere except at the pulse. The drive-enable hold property also assumes that `ode_i` does not change inside a slot unless the slot's enable is allowed to change with it. The bench generates the frame pulse from its own cycle count and changes `ode_i` only on frame boundaries. It issues host writes only in a window early in the first frame, after the reset-state slots have been observed. That keeps every checked slot clear of a word or offset that changes while its byte is being fetched.

// File: rtl/tsi_pkg.sv
// Shared sizes and the connection word layout for the time slot switch.
// Assumes 8-bit channels and power-of-two stream and channel counts.
package tsi_pkg;
    localparam int unsigned N_STR  = 16;
    localparam int unsigned N_CH   = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned STR_W  = $clog2(N_STR);
    localparam int unsigned CH_W   = $clog2(N_CH);
    localparam int unsigned BIT_W  = $clog2(BYTE_W);
    localparam int unsigned POS_W  = CH_W + BIT_W;
    localparam int unsigned CFG_AW = 1 + STR_W + CH_W;

    // Connection word: drive enable, host byte select, fixed delay, source.
    typedef struct packed {
        logic             drive;
        logic             host;
        logic             fixed_dly;
        logic [STR_W-1:0] src_str;
        logic [CH_W-1:0]  src_ch;
    } cm_word_t;

    localparam int unsigned CM_W = $bits(cm_word_t);
endpackage

// File: rtl/tsi_frame_timer.sv
// Frame position counter. The frame pulse forces position 0 in its own
// cycle; otherwise the position steps by one. A parity bit flips after the
// last position so two frames can be told apart. Assumes a regular pulse.
module tsi_frame_timer #(
    parameter int unsigned POS_W = tsi_pkg::POS_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             fp_i,
    output logic [POS_W-1:0] pos_o,
    output logic             par_o
);
    logic [POS_W-1:0] cnt_q;
    logic             par_q;

    assign pos_o = fp_i ? '0 : cnt_q;
    assign par_o = par_q;

    // Advance the position and flip parity at the frame's last bit.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
            par_q <= 1'b0;
        end else begin
            cnt_q <= pos_o + 1'b1;
            if (pos_o == '1) par_q <= ~par_q;
        end
    end
endmodule

// File: rtl/tsi_rx_lane.sv
// One receive line. Derives the line's own position from the global position
// and its bit offset, shifts bits in MSB first and raises a write for each
// completed channel. The page is the parity of the line's own frame.
module tsi_rx_lane #(
    parameter int unsigned POS_W  = tsi_pkg::POS_W,
    parameter int unsigned BIT_W  = tsi_pkg::BIT_W,
    parameter int unsigned BYTE_W = tsi_pkg::BYTE_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic [POS_W-1:0]       pos_i,
    input  logic                   par_i,
    input  logic [POS_W-1:0]       ofs_i,
    input  logic                   rx_i,
    output logic [POS_W-1:0]       lpos_o,
    output logic                   lpage_o,
    output logic                   we_o,
    output logic [POS_W-BIT_W-1:0] wch_o,
    output logic [BYTE_W-1:0]      wbyte_o
);
    logic [BYTE_W-1:0] sr_q;

    assign lpos_o  = pos_i - ofs_i;
    assign lpage_o = par_i ^ (pos_i < ofs_i);
    assign we_o    = (lpos_o[BIT_W-1:0] == '1);
    assign wch_o   = lpos_o[POS_W-1:BIT_W];
    assign wbyte_o = {sr_q[BYTE_W-2:0], rx_i};

    // Shift the serial bit into the assembly register.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= wbyte_o;
    end
endmodule

// File: rtl/tsi_data_mem.sv
// Two-page data memory: one write port per receive line, one read port per
// transmit line. A read of the entry being written in the same cycle returns
// the new byte. Assumes each line writes only its own row.
module tsi_data_mem #(
    parameter int unsigned NSTR   = tsi_pkg::N_STR,
    parameter int unsigned NCH    = tsi_pkg::N_CH,
    parameter int unsigned BYTE_W = tsi_pkg::BYTE_W,
    localparam int unsigned SW    = $clog2(NSTR),
    localparam int unsigned CW    = $clog2(NCH)
) (
    input  logic              clk_i,
    input  logic              we_i    [NSTR],
    input  logic              wpage_i [NSTR],
    input  logic [CW-1:0]     wch_i   [NSTR],
    input  logic [BYTE_W-1:0] wbyte_i [NSTR],
    input  logic              rpage_i [NSTR],
    input  logic [SW-1:0]     rstr_i  [NSTR],
    input  logic [CW-1:0]     rch_i   [NSTR],
    output logic [BYTE_W-1:0] rdata_o [NSTR]
);
    logic [BYTE_W-1:0] mem_q [2][NSTR][NCH];

    // Store every completed channel byte in its line's row.
    always_ff @(posedge clk_i) begin
        for (int s = 0; s < NSTR; s++) begin
            if (we_i[s]) mem_q[wpage_i[s]][s][wch_i[s]] <= wbyte_i[s];
        end
    end

    for (genvar r = 0; r < NSTR; r++) begin : g_rd
        // Read one entry, forwarding a same-cycle write to it.
        always_comb begin
            rdata_o[r] = mem_q[rpage_i[r]][rstr_i[r]][rch_i[r]];
            if (we_i[rstr_i[r]] && (wpage_i[rstr_i[r]] == rpage_i[r]) &&
                (wch_i[rstr_i[r]] == rch_i[r]))
                rdata_o[r] = wbyte_i[rstr_i[r]];
        end
    end
endmodule

// File: rtl/tsi_tx_lane.sv
// One transmit line. On the load strobe it takes either the switched byte or
// the host byte of the connection word, plus the drive bit, then shifts the
// byte out MSB first. The enable is gated by the global drive input.
module tsi_tx_lane #(
    parameter int unsigned BYTE_W = tsi_pkg::BYTE_W
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                load_i,
    input  tsi_pkg::cm_word_t   word_i,
    input  logic [BYTE_W-1:0]   mem_byte_i,
    input  logic                ode_i,
    output logic                tx_o,
    output logic                oe_o
);
    logic [tsi_pkg::CM_W-1:0] raw;
    logic [BYTE_W-1:0]        sr_q;
    logic                     drv_q;

    assign raw  = word_i;
    assign tx_o = sr_q[BYTE_W-1];
    assign oe_o = drv_q & ode_i;

    // Load the next slot's byte and enable, or shift the current byte.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sr_q  <= '0;
            drv_q <= 1'b0;
        end else if (load_i) begin
            sr_q  <= word_i.host ? raw[BYTE_W-1:0] : mem_byte_i;
            drv_q <= word_i.drive;
        end else begin
            sr_q  <= {sr_q[BYTE_W-2:0], 1'b0};
        end
    end
endmodule

// File: rtl/tsi_switch.sv
// Time slot interchange top. Holds the connection words and line offsets
// written by the host. In the last bit of each slot it looks up the next
// slot's word, picks the data page from the delay mode and loads the
// transmit lanes. Assumes one clock per serial bit and a regular frame pulse.
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int unsigned NSTR = tsi_pkg::N_STR,
    parameter int unsigned NCH  = tsi_pkg::N_CH
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fp_i,
    input  logic [NSTR-1:0]   rx_i,
    input  logic              ode_i,
    input  logic              cfg_we_i,
    input  logic              cfg_blk_i,
    input  logic [CFG_AW-1:0] cfg_addr_i,
    input  logic [CM_W-1:0]   cfg_wdata_i,
    output logic [NSTR-1:0]   tx_o,
    output logic [NSTR-1:0]   tx_oe_o
);
    localparam int unsigned SW = $clog2(NSTR);
    localparam int unsigned CW = $clog2(NCH);
    localparam int unsigned PW = CW + BIT_W;

    logic [PW-1:0]     pos;
    logic              par;
    logic              load;
    logic [CW-1:0]     nslot;
    logic              opar;
    cm_word_t          cm_q  [NSTR][NCH];
    logic [PW-1:0]     ofs_q [NSTR];
    logic [SW-1:0]     a_str;
    logic [CW-1:0]     a_ch;

    logic [PW-1:0]     lpos  [NSTR];
    logic              lpage [NSTR];
    logic              we    [NSTR];
    logic [CW-1:0]     wch   [NSTR];
    logic [BYTE_W-1:0] wbyte [NSTR];
    logic              rpage [NSTR];
    logic [SW-1:0]     rstr  [NSTR];
    logic [CW-1:0]     rch   [NSTR];
    logic [BYTE_W-1:0] rdata [NSTR];

    tsi_frame_timer #(.POS_W(PW)) u_timer (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .fp_i  (fp_i),
        .pos_o (pos),
        .par_o (par)
    );

    assign load  = (pos[BIT_W-1:0] == '1);
    assign nslot = pos[PW-1:BIT_W] + 1'b1;
    assign opar  = (pos == '1) ? ~par : par;
    assign a_str = cfg_addr_i[CW +: SW];
    assign a_ch  = cfg_addr_i[CW-1:0];

    // Apply host writes: offsets, single connection words, block fills.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int o = 0; o < NSTR; o++) begin
                ofs_q[o] <= '0;
                for (int c = 0; c < NCH; c++) cm_q[o][c] <= '0;
            end
        end else if (cfg_we_i) begin
            if (cfg_addr_i[CFG_AW-1]) begin
                ofs_q[cfg_addr_i[SW-1:0]] <= cfg_wdata_i[PW-1:0];
            end else if (cfg_blk_i) begin
                for (int c = 0; c < NCH; c++) cm_q[a_str][c] <= cm_word_t'(cfg_wdata_i);
            end else begin
                cm_q[a_str][a_ch] <= cm_word_t'(cfg_wdata_i);
            end
        end
    end

    for (genvar s = 0; s < NSTR; s++) begin : g_rx
        tsi_rx_lane #(.POS_W(PW), .BIT_W(BIT_W), .BYTE_W(BYTE_W)) u_rx (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .pos_i  (pos),
            .par_i  (par),
            .ofs_i  (ofs_q[s]),
            .rx_i   (rx_i[s]),
            .lpos_o (lpos[s]),
            .lpage_o(lpage[s]),
            .we_o   (we[s]),
            .wch_o  (wch[s]),
            .wbyte_o(wbyte[s])
        );
    end

    tsi_data_mem #(.NSTR(NSTR), .NCH(NCH), .BYTE_W(BYTE_W)) u_mem (
        .clk_i  (clk_i),
        .we_i   (we),
        .wpage_i(lpage),
        .wch_i  (wch),
        .wbyte_i(wbyte),
        .rpage_i(rpage),
        .rstr_i (rstr),
        .rch_i  (rch),
        .rdata_o(rdata)
    );

    for (genvar o = 0; o < NSTR; o++) begin : g_tx
        cm_word_t word;
        logic     done;

        assign word = cm_q[o][nslot];

        // Choose the page: previous frame when fixed, newest copy otherwise.
        always_comb begin
            done     = ({word.src_ch, {BIT_W{1'b1}}} <= lpos[word.src_str]);
            rstr[o]  = word.src_str;
            rch[o]   = word.src_ch;
            if (word.fixed_dly) rpage[o] = ~opar;
            else if (done)      rpage[o] = lpage[word.src_str];
            else                rpage[o] = ~lpage[word.src_str];
        end

        tsi_tx_lane #(.BYTE_W(BYTE_W)) u_tx (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .load_i    (load),
            .word_i    (word),
            .mem_byte_i(rdata[o]),
            .ode_i     (ode_i),
            .tx_o      (tx_o[o]),
            .oe_o      (tx_oe_o[o])
        );
    end
endmodule

// File: rtl/tsi_switch_chk.sv
// Property checker for the switch, attached by bind. Observes the frame
// position, the global drive input and the per-line enables.
module tsi_switch_chk #(
    parameter int unsigned POS_W = tsi_pkg::POS_W,
    parameter int unsigned NSTR  = tsi_pkg::N_STR
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             fp_i,
    input logic             ode_i,
    input logic [POS_W-1:0] pos_i,
    input logic [NSTR-1:0]  tx_oe_i
);
    logic run_q;

    // Mark that at least one cycle has passed since reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) run_q <= 1'b0;
        else         run_q <= 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_q |-> (tx_oe_i == '0));

    // R2
    frame_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && !fp_i) |-> (pos_i == POS_W'($past(pos_i) + 1'b1)));

    // R4
    slot_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (run_q && (pos_i[2:0] != 3'd0) && $stable(ode_i)) |-> $stable(tx_oe_i));

    // R5
    ode_kill_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ode_i |-> (tx_oe_i == '0));
endmodule

bind tsi_switch tsi_switch_chk #(.POS_W(PW), .NSTR(NSTR)) u_chk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fp_i   (fp_i),
    .ode_i  (ode_i),
    .pos_i  (pos),
    .tx_oe_i(tx_oe_o)
);

// File: tb/tsi_switch_test.sv
// Scoreboard bench: expected slots are queued up front; a monitor collects
// each transmitted slot and compares it with the queue head.
module tsi_switch_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fp = 1'b0;
    logic [15:0] rx = '0;
    logic        ode = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_blk = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic [15:0] tx;
    logic [15:0] tx_oe;

    typedef struct {
        int         f;
        int         o;
        int         n;
        bit         oe;
        logic [7:0] b;
        string      tag;
    } item_t;

    item_t      q[$];
    int         checks = 0;
    int         errors = 0;
    bit         run = 0;
    bit         done = 0;
    int         t = 0;
    int         p, f;
    int         ofs_b [16];
    logic [7:0] acc [16];
    bit         oe_all [16];
    bit         oe_any [16];

    tsi_switch uut (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .fp_i       (fp),
        .rx_i       (rx),
        .ode_i      (ode),
        .cfg_we_i   (cfg_we),
        .cfg_blk_i  (cfg_blk),
        .cfg_addr_i (cfg_addr),
        .cfg_wdata_i(cfg_wdata),
        .tx_o       (tx),
        .tx_oe_o    (tx_oe)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] in_b(int s, int c, int fr);
        return 8'(s * 29 + c * 7 + fr * 101 + 3);
    endfunction

    function automatic logic [11:0] wd(bit drv, bit host, bit fixd, int s, int c);
        return {drv, host, fixd, 4'(s), 5'(c)};
    endfunction

    task automatic push(int fr, int o, int n, bit oe, logic [7:0] b, string tag);
        item_t it;
        it.f = fr; it.o = o; it.n = n; it.oe = oe; it.b = b; it.tag = tag;
        q.push_back(it);
    endtask

    task automatic cfg_wr(bit blk, logic [9:0] a, logic [11:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_blk = blk; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0; cfg_blk = 1'b0;
    endtask

    // Drive frame pulse, data and drive enable, then sample the outputs.
    always @(negedge clk) begin
        if (run) begin
            p = t % 256;
            f = t / 256;
            fp  = (p == 0);
            ode = (f != 3);
            for (int s = 0; s < 16; s++) begin
                int lp, lf;
                logic [7:0] b;
                lp = (p - ofs_b[s] + 256) % 256;
                lf = (p >= ofs_b[s]) ? f : f - 1;
                b  = in_b(s, lp / 8, lf);
                rx[s] = b[7 - (lp % 8)];
            end
            #1;
            for (int o = 0; o < 16; o++) begin
                if (p % 8 == 0) begin
                    oe_all[o] = 1'b1;
                    oe_any[o] = 1'b0;
                end
                acc[o]    = {acc[o][6:0], tx[o]};
                oe_all[o] = oe_all[o] & tx_oe[o];
                oe_any[o] = oe_any[o] | tx_oe[o];
            end
            if (p % 8 == 7) begin
                while (q.size() > 0 && q[0].f == f && q[0].n == p / 8) begin
                    item_t it;
                    bit ok;
                    it = q.pop_front();
                    checks++;
                    if (it.oe) ok = oe_all[it.o] && (acc[it.o] == it.b);
                    else       ok = !oe_any[it.o];
                    if (!ok) begin
                        errors++;
                        $display("FAIL %s frame=%0d line=%0d slot=%0d: got byte=%h oe_all=%b oe_any=%b, expected byte=%h oe=%b",
                                 it.tag, f, it.o, it.n, acc[it.o], oe_all[it.o],
                                 oe_any[it.o], it.b, it.oe);
                    end
                end
            end
            t++;
        end
    end

    initial begin
        for (int s = 0; s < 16; s++) ofs_b[s] = 0;
        ofs_b[5] = 3;
        ofs_b[9] = 8;

        // R1: nothing drives in the first two slots after reset.
        for (int n = 0; n < 2; n++)
            for (int o = 0; o < 16; o++) push(0, o, n, 1'b0, 8'h00, "R1");
        for (int fr = 1; fr <= 2; fr++) begin
            push(fr, 1, 0, 1'b1, in_b(0, 31, fr - 1), "R2");
            push(fr, 6, 0, 1'b1, 8'h3C, "R8");
            push(fr, 2, 3, 1'b1, in_b(4, 20, fr - 1), "R3");
            push(fr, 0, 4, 1'b1, in_b(3, 10, fr - 1), "R2");
            push(fr, 7, 5, 1'b0, 8'h00, "R1");
            push(fr, 3, 6, 1'b1, 8'hA5, "R6");
            push(fr, 2, 7, 1'b1, in_b(4, 7, fr - 1), "R3");
            push(fr, 3, 8, 1'b0, 8'h00, "R4");
            push(fr, 4, 9, 1'b1, in_b(5, 6, fr - 1), "R7");
            push(fr, 2, 12, 1'b1, in_b(4, 5, fr), "R3");
            push(fr, 6, 15, 1'b1, 8'h3C, "R8");
            push(fr, 4, 20, 1'b1, in_b(9, 1, fr), "R7");
            push(fr, 15, 31, 1'b1, in_b(15, 0, fr - 1), "R2");
            push(fr, 6, 31, 1'b1, 8'h3C, "R8");
        end
        push(3, 3, 6, 1'b0, 8'h00, "R5");
        push(3, 6, 31, 1'b0, 8'h00, "R5");
        push(4, 3, 6, 1'b1, 8'hA5, "R5");

        repeat (4) @(posedge clk);
        rst_n <= 1'b1;
        run   <= 1'b1;

        wait (t >= 16);
        // R9: offsets through the offset address space.
        cfg_wr(1'b0, 10'(512 | 5), 12'd3);
        cfg_wr(1'b0, 10'(512 | 9), 12'd8);
        cfg_wr(1'b0, 10'((1 << 5) | 0),  wd(1, 0, 1, 0, 31));
        cfg_wr(1'b0, 10'((0 << 5) | 4),  wd(1, 0, 1, 3, 10));
        cfg_wr(1'b0, 10'((15 << 5) | 31), wd(1, 0, 1, 15, 0));
        cfg_wr(1'b0, 10'((2 << 5) | 12), wd(1, 0, 0, 4, 5));
        cfg_wr(1'b0, 10'((2 << 5) | 3),  wd(1, 0, 0, 4, 20));
        cfg_wr(1'b0, 10'((2 << 5) | 7),  wd(1, 0, 0, 4, 7));
        cfg_wr(1'b0, 10'((3 << 5) | 6),  12'hCA5);
        cfg_wr(1'b0, 10'((3 << 5) | 8),  wd(0, 0, 1, 1, 1));
        cfg_wr(1'b0, 10'((4 << 5) | 9),  wd(1, 0, 1, 5, 6));
        cfg_wr(1'b0, 10'((4 << 5) | 20), wd(1, 0, 0, 9, 1));
        cfg_wr(1'b1, 10'((6 << 5) | 0),  12'hC3C);

        wait (t >= 5 * 256 + 2);
        while (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            errors++;
            $display("FAIL %s frame=%0d line=%0d slot=%0d: got no slot, expected byte=%h oe=%b",
                     it.tag, it.f, it.o, it.n, it.b, it.oe);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule